// File: doc/BRIEF.md
# Self-Checking Duplicated Dual-Rail Adder

This block adds two unsigned operands and tolerates a single internal fault through redundancy. It holds two identical copies of the adder, a primary copy and a spare copy. Each copy runs two ripple-carry chains side by side. The true rail adds the operands as given. The complement rail adds the inverted operands with a carry-in of one. Because a full adder is self-dual, every complement-rail sum and carry bit is the exact inverse of the matching true-rail bit. Each copy watches both rails. It raises a sum-error flag when any sum position shows equal values on the two rails, and a separate carry-error flag when any carry position does.

The result multiplexers pass the primary copy's true-rail sum and carry-out. When the primary copy flags an error on an output, that output is taken from the spare copy instead. A combined flag reports the case where both copies flag the same output, which cannot be corrected. Every internal sum and carry net of all four chains can be inverted through XOR fault-injection masks, so single and double faults can be forced. With all masks zero the block is a plain adder. The block is purely combinational.

Top module: `dual_rail_sec_adder`

## Requirements
- R1: With all injection masks zero, `{carry_out, sum}` equals `a + b` for every operand pair.
- R2: With all injection masks zero, all four error flags and `uncorrectable` are low.
- R3: Mask layout. Chain index k is 0 for primary-true, 1 for primary-complement, 2 for spare-true and 3 for spare-complement. Bit `k*WIDTH+i` of `inj_sum` inverts sum bit i of chain k. The same bit of `inj_carry` inverts the carry out of bit position i of chain k, and that inverted carry also feeds position i+1.
- R4: A single sum-bit fault in any chain raises that copy's sum-error flag only. The other copy's flags and the copy's own carry-error flag stay low.
- R5: A single carry fault at position i in any chain raises that copy's carry-error flag. It also raises the copy's sum-error flag when i is below WIDTH-1. The other copy's flags stay low.
- R6: With any single fault inside the primary copy, `sum` and `carry_out` still equal `a + b`, because the flagged outputs are taken from the spare copy.
- R7: With any single fault inside the spare copy, `sum` and `carry_out` still equal `a + b`, taken from the primary copy.
- R8: `uncorrectable` is high exactly when both copies flag a sum error, or both copies flag a carry error. A sum error in one copy combined with a carry error only in the other leaves it low, and both outputs stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| inj_sum | input | 4*WIDTH | XOR masks on the sum nets of the four chains |
| inj_carry | input | 4*WIDTH | XOR masks on the carry nets of the four chains |
| sum | output | WIDTH | Corrected sum |
| carry_out | output | 1 | Corrected carry-out |
| pri_sum_err | output | 1 | Primary copy rails disagree on a sum bit |
| pri_carry_err | output | 1 | Primary copy rails disagree on a carry bit |
| spr_sum_err | output | 1 | Spare copy rails disagree on a sum bit |
| spr_carry_err | output | 1 | Spare copy rails disagree on a carry bit |
| uncorrectable | output | 1 | Both copies flag the same output |

## Verification
The bench aims at faults on carry nets, because an inverted carry runs into the next position. A design that compared only sum bits, or did not route the injected carry forward, would show the wrong flag pattern or let a bad carry-out through. It puts a fault on the top bit's carry, where no higher sum bit is disturbed. A design that raised the sum flag there anyway would be caught. It also mixes a sum fault in one copy with a carry fault in the other. A design that ORed all four flags into `uncorrectable` would raise it wrongly, and a design that steered both outputs together would return a wrong sum.

// File: rtl/dra_pkg.sv
package dra_pkg;

   parameter int unsigned DRA_CHAINS = 4;

   typedef enum logic [1:0] {
      CH_PRI_TRUE = 2'd0,
      CH_PRI_COMP = 2'd1,
      CH_SPR_TRUE = 2'd2,
      CH_SPR_COMP = 2'd3
   } chain_e;

endpackage

// File: rtl/dra_full_cell.sv
module dra_full_cell (
   input  logic x,
   input  logic y,
   input  logic cin,
   input  logic sum_flip,
   input  logic carry_flip,
   output logic s,
   output logic co
);
   logic s_raw;
   logic co_raw;

   always_comb begin
      s_raw  = x ^ y ^ cin;
      co_raw = (x & y) | (x & cin) | (y & cin);
      s      = s_raw ^ sum_flip;
      co     = co_raw ^ carry_flip;
   end
endmodule

// File: rtl/dra_ripple_chain.sv
module dra_ripple_chain #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          COMP_RAIL = 1'b0
) (
   input  logic [WIDTH-1:0] op_x,
   input  logic [WIDTH-1:0] op_y,
   input  logic [WIDTH-1:0] sum_flip,
   input  logic [WIDTH-1:0] carry_flip,
   output logic [WIDTH-1:0] sum_bits,
   output logic [WIDTH-1:0] carry_bits
);
   logic [WIDTH-1:0] x_in;
   logic [WIDTH-1:0] y_in;
   logic             cin0;

   generate
      if (COMP_RAIL) begin : g_comp
         assign x_in = ~op_x;
         assign y_in = ~op_y;
         assign cin0 = 1'b1;
      end else begin : g_true
         assign x_in = op_x;
         assign y_in = op_y;
         assign cin0 = 1'b0;
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic cin_i;
         if (gi == 0) begin : g_lsb
            assign cin_i = cin0;
         end else begin : g_mid
            assign cin_i = carry_bits[gi-1];
         end
         dra_full_cell u_cell (
            .x          (x_in[gi]),
            .y          (y_in[gi]),
            .cin        (cin_i),
            .sum_flip   (sum_flip[gi]),
            .carry_flip (carry_flip[gi]),
            .s          (sum_bits[gi]),
            .co         (carry_bits[gi])
         );
      end
   endgenerate
endmodule

// File: rtl/dra_rail_compare.sv
module dra_rail_compare #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_c,
   output logic             mismatch
);
   logic [WIDTH-1:0] same;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_cmp
         assign same[gi] = ~(rail_t[gi] ^ rail_c[gi]);
      end
   endgenerate

   assign mismatch = |same;
endmodule

// File: rtl/dra_copy.sv
module dra_copy #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] t_sum_flip,
   input  logic [WIDTH-1:0] t_carry_flip,
   input  logic [WIDTH-1:0] c_sum_flip,
   input  logic [WIDTH-1:0] c_carry_flip,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             sum_err,
   output logic             carry_err
);
   logic [WIDTH-1:0] t_sum, t_carry, c_sum, c_carry;

   dra_ripple_chain #(.WIDTH(WIDTH), .COMP_RAIL(1'b0)) u_true (
      .op_x(a), .op_y(b), .sum_flip(t_sum_flip), .carry_flip(t_carry_flip),
      .sum_bits(t_sum), .carry_bits(t_carry)
   );

   dra_ripple_chain #(.WIDTH(WIDTH), .COMP_RAIL(1'b1)) u_comp (
      .op_x(a), .op_y(b), .sum_flip(c_sum_flip), .carry_flip(c_carry_flip),
      .sum_bits(c_sum), .carry_bits(c_carry)
   );

   dra_rail_compare #(.WIDTH(WIDTH)) u_cmp_sum (
      .rail_t(t_sum), .rail_c(c_sum), .mismatch(sum_err)
   );

   dra_rail_compare #(.WIDTH(WIDTH)) u_cmp_carry (
      .rail_t(t_carry), .rail_c(c_carry), .mismatch(carry_err)
   );

   assign sum  = t_sum;
   assign cout = t_carry[WIDTH-1];

   // R4 R5: a copy with no injected fault never reports one
   always_comb begin
      if ((t_sum_flip | t_carry_flip | c_sum_flip | c_carry_flip) == '0) begin
         a_r4_clean_copy_quiet : assert (!sum_err && !carry_err)
            else $error("copy flagged an error with no fault injected");
      end
   end
endmodule

// File: rtl/dual_rail_sec_adder.sv
module dual_rail_sec_adder #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0]                     a,
   input  logic [WIDTH-1:0]                     b,
   input  logic [dra_pkg::DRA_CHAINS*WIDTH-1:0] inj_sum,
   input  logic [dra_pkg::DRA_CHAINS*WIDTH-1:0] inj_carry,
   output logic [WIDTH-1:0]                     sum,
   output logic                                 carry_out,
   output logic                                 pri_sum_err,
   output logic                                 pri_carry_err,
   output logic                                 spr_sum_err,
   output logic                                 spr_carry_err,
   output logic                                 uncorrectable
);
   import dra_pkg::*;

   localparam int unsigned OFS_PT = int'(CH_PRI_TRUE) * WIDTH;
   localparam int unsigned OFS_PC = int'(CH_PRI_COMP) * WIDTH;
   localparam int unsigned OFS_ST = int'(CH_SPR_TRUE) * WIDTH;
   localparam int unsigned OFS_SC = int'(CH_SPR_COMP) * WIDTH;
   localparam int unsigned HALF   = 2 * WIDTH;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dual_rail_sec_adder: WIDTH must be at least 1");
      end
      if (DRA_CHAINS != 4) begin : g_bad_chains
         $error("dual_rail_sec_adder: exactly four chains expected");
      end
   endgenerate

   logic [WIDTH-1:0] p_sum, s_sum;
   logic             p_cout, s_cout;

   dra_copy #(.WIDTH(WIDTH)) u_pri (
      .a(a), .b(b),
      .t_sum_flip  (inj_sum  [OFS_PT +: WIDTH]),
      .t_carry_flip(inj_carry[OFS_PT +: WIDTH]),
      .c_sum_flip  (inj_sum  [OFS_PC +: WIDTH]),
      .c_carry_flip(inj_carry[OFS_PC +: WIDTH]),
      .sum(p_sum), .cout(p_cout),
      .sum_err(pri_sum_err), .carry_err(pri_carry_err)
   );

   dra_copy #(.WIDTH(WIDTH)) u_spr (
      .a(a), .b(b),
      .t_sum_flip  (inj_sum  [OFS_ST +: WIDTH]),
      .t_carry_flip(inj_carry[OFS_ST +: WIDTH]),
      .c_sum_flip  (inj_sum  [OFS_SC +: WIDTH]),
      .c_carry_flip(inj_carry[OFS_SC +: WIDTH]),
      .sum(s_sum), .cout(s_cout),
      .sum_err(spr_sum_err), .carry_err(spr_carry_err)
   );

   always_comb begin
      sum           = pri_sum_err   ? s_sum  : p_sum;
      carry_out     = pri_carry_err ? s_cout : p_cout;
      uncorrectable = (pri_sum_err & spr_sum_err) | (pri_carry_err & spr_carry_err);
   end

   logic [WIDTH:0] ref_total;
   logic           pri_clean, spr_clean;

   always_comb begin
      ref_total = {1'b0, a} + {1'b0, b};
      pri_clean = (inj_sum[0 +: HALF] | inj_carry[0 +: HALF]) == '0;
      spr_clean = (inj_sum[HALF +: HALF] | inj_carry[HALF +: HALF]) == '0;
      if (pri_clean && spr_clean) begin
         a_r1_clean_add : assert ({carry_out, sum} == ref_total)
            else $error("fault-free result differs from a+b");
         a_r2_clean_flags : assert (!uncorrectable && !pri_sum_err && !spr_sum_err)
            else $error("fault-free adder raised a flag");
      end
      if (spr_clean && $countones({inj_sum[0 +: HALF], inj_carry[0 +: HALF]}) == 1) begin
         a_r6_primary_fault_masked : assert ({carry_out, sum} == ref_total && !uncorrectable)
            else $error("single primary fault reached the outputs");
      end
      if (pri_clean && $countones({inj_sum[HALF +: HALF], inj_carry[HALF +: HALF]}) == 1) begin
         a_r7_spare_fault_masked : assert ({carry_out, sum} == ref_total && !uncorrectable)
            else $error("single spare fault reached the outputs");
      end
   end
endmodule

// File: tb/dual_rail_sec_adder_test.sv
`timescale 1ns/1ps
module dual_rail_sec_adder_test;
   localparam int W  = 8;
   localparam int NC = 4;

   logic [W-1:0]    a, b;
   logic [NC*W-1:0] inj_sum, inj_carry;
   logic [W-1:0]    sum;
   logic            carry_out, pse, pce, sse, sce, unc;

   int checks = 0;
   int errors = 0;
   bit clk = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   dual_rail_sec_adder #(.WIDTH(W)) uut (
      .a(a), .b(b), .inj_sum(inj_sum), .inj_carry(inj_carry),
      .sum(sum), .carry_out(carry_out),
      .pri_sum_err(pse), .pri_carry_err(pce),
      .spr_sum_err(sse), .spr_carry_err(sce),
      .uncorrectable(unc)
   );

   task automatic check_vec(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h", req, a, b, act, exp);
      end
   endtask

   task automatic apply(input int av, input int bv, input logic [NC*W-1:0] ms,
                        input logic [NC*W-1:0] mc);
      @(posedge clk);
      a = W'(av); b = W'(bv); inj_sum = ms; inj_carry = mc;
      @(negedge clk);
   endtask

   // flags packed as {unc, spr_carry, spr_sum, pri_carry, pri_sum}
   function automatic logic [4:0] flags_now();
      return {unc, sce, sse, pce, pse};
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; inj_sum = '0; inj_carry = '0;
      // reset-state check: zero inputs give zero outputs, no flags
      apply(0, 0, '0, '0);
      check_vec("R2 idle", {27'd0, flags_now()}, 32'd0);
      check_vec("R1 idle", {23'd0, carry_out, sum}, 32'd0);

      // R1 R2: exhaustive fault-free sweep
      for (int av = 0; av < (1 << W); av++) begin
         for (int bv = 0; bv < (1 << W); bv++) begin
            apply(av, bv, '0, '0);
            check_vec("R1", {23'd0, carry_out, sum}, 32'(av + bv));
            check_vec("R2", {27'd0, flags_now()}, 32'd0);
         end
      end

      // R3 R4 R5 R6 R7: every single fault over a spread of operands
      for (int ch = 0; ch < NC; ch++) begin
         for (int kind = 0; kind < 2; kind++) begin
            for (int bit_i = 0; bit_i < W; bit_i++) begin
               for (int av = 0; av < (1 << W); av += 3) begin
                  logic [NC*W-1:0] ms, mc;
                  logic            sf, cf;
                  logic [4:0]      expf;
                  int              bv;
                  bv = (av * 73 + 29 + bit_i) % (1 << W);
                  ms = '0; mc = '0;
                  if (kind == 0) ms[ch*W + bit_i] = 1'b1;
                  else           mc[ch*W + bit_i] = 1'b1;
                  sf = (kind == 0) || (bit_i < W - 1);
                  cf = (kind == 1);
                  expf = (ch < 2) ? {3'b000, cf, sf} : {1'b0, cf, sf, 2'b00};
                  apply(av, bv, ms, mc);
                  if (kind == 0) check_vec("R4 R3 flags", {27'd0, flags_now()}, {27'd0, expf});
                  else           check_vec("R5 R3 flags", {27'd0, flags_now()}, {27'd0, expf});
                  if (ch < 2) check_vec("R6", {23'd0, carry_out, sum}, 32'(av + bv));
                  else        check_vec("R7", {23'd0, carry_out, sum}, 32'(av + bv));
               end
            end
         end
      end

      // R8: double faults
      for (int bit_i = 0; bit_i < W; bit_i++) begin
         for (int av = 0; av < (1 << W); av += 17) begin
            logic [NC*W-1:0] ms, mc;
            int bv;
            bv = (av * 5 + 3) % (1 << W);
            // sum fault in both copies
            ms = '0; mc = '0;
            ms[0*W + bit_i] = 1'b1; ms[2*W + bit_i] = 1'b1;
            apply(av, bv, ms, mc);
            check_vec("R8 both sum", {31'd0, unc}, 32'd1);
            // carry fault in both complement rails
            ms = '0; mc = '0;
            mc[1*W + bit_i] = 1'b1; mc[3*W + bit_i] = 1'b1;
            apply(av, bv, ms, mc);
            check_vec("R8 both carry", {31'd0, unc}, 32'd1);
            // primary sum fault, spare top-bit carry fault: correctable
            ms = '0; mc = '0;
            ms[0*W + bit_i] = 1'b1; mc[2*W + W - 1] = 1'b1;
            apply(av, bv, ms, mc);
            check_vec("R8 mixed flag", {27'd0, flags_now()}, {27'd0, 5'b01001});
            check_vec("R8 mixed result", {23'd0, carry_out, sum}, 32'(av + bv));
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule